// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks, for every hardware thread of an out-of-order front end, the condition of its instruction fetch: running, squashing, blocked, waiting for a cache line, or holding a returned line. Once per clock it folds in block and unblock pulses from four downstream stages, redirect requests from the commit and decode stages, a flag that says a squash is still draining, and cache events. From these it produces the next status of each thread, the program counter to resume from, and a stage-wide active flag.

Each thread owns four sticky stall bits, one per downstream stage. Status changes follow a fixed precedence: a commit redirect wins, then a draining squash, then a decode redirect, then a stall, and finally recovery to Running. The block does not hold the branch predictor. It emits pulses that tell the predictor to repair or retire, and it emits a flush pulse for each redirect.

Top module: `fetch_thread_status`

## Requirements
- R1: After reset, every thread status is Running (code 0) and every stall bit is clear. Each thread PC is RESET_PC and each next PC is RESET_PC+4. `active_o` is 1, and `chg_o`, `wake_o` and `sleep_o` are 0.
- R2: Stall bit `t*4+s` belongs to thread t and stage s, in the order decode=0, rename=1, execute=2, commit=3. A block pulse sets the bit and an unblock pulse clears it. Otherwise the bit holds its value.
- R3: A commit redirect (`late_sq_i`) takes precedence over every other input. On the next edge the thread status is Squashing (code 2), the PC is the supplied target, the next PC is target+4, and `flush_o` pulses.
- R4: Without a commit redirect, the draining flag `sq_busy_i` puts the thread in Squashing, or keeps it there, and leaves the PC unchanged.
- R5: A decode redirect (`early_sq_i`) loads the early target and enters Squashing only when the thread is not already Squashing. Otherwise it leaves the PC untouched.
- R6: When any stall bit of the thread (after this cycle's pulses) or `ctx_switch_i` is set, the thread becomes Blocked (code 3), unless it is in WaitResponse (code 4).
- R7: Without any of the conditions above, a thread in Blocked or Squashing returns to Running.
- R8: `miss_i` moves a Running thread to WaitResponse. `resp_i` moves a WaitResponse thread to AccessComplete (code 6), or to Blocked if it is stalled. `resp_i` has no effect in any other status.
- R9: A thread in AccessComplete returns to Running when `sel_i` selects it.
- R10: `chg_o` pulses in the cycle after any thread status changes. Only on such a change is `active_o` recomputed: it is 1 if some thread with `thr_act_i` set is in Running, Squashing or AccessComplete. `wake_o` and `sleep_o` pulse on the resulting 0-to-1 and 1-to-0 transitions of `active_o`.
- R11: `bp_squash_o` pulses for a commit redirect, or for a decode redirect with no commit redirect and no draining flag. In either case `bp_fix_o` carries the mispredict flag of the source that acted. `bp_update_o` pulses for `done_i` when there is no commit redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_i | input | NT*NS | Block pulses, bit t*NS+s |
| unb_i | input | NT*NS | Unblock pulses, bit t*NS+s |
| ctx_switch_i | input | 1 | Global context-switch stall |
| late_sq_i | input | NT | Commit-stage redirect |
| late_mp_i | input | NT | Commit redirect is a mispredict |
| late_tgt_i | input | NT*AW | Commit redirect targets |
| done_i | input | NT | Completed-branch notice for predictor update |
| sq_busy_i | input | NT | Squash still draining |
| early_sq_i | input | NT | Decode-stage redirect |
| early_mp_i | input | NT | Decode redirect is a mispredict |
| early_tgt_i | input | NT*AW | Decode redirect targets |
| miss_i | input | NT | Cache line request issued |
| resp_i | input | NT | Cache line returned |
| sel_i | input | NT | Thread selected for fetch |
| thr_act_i | input | NT | Thread is active |
| status_o | output | NT*3 | Status codes, 3 bits per thread |
| stall_o | output | NT*NS | Sticky stall bits |
| pc_o | output | NT*AW | Thread PCs |
| npc_o | output | NT*AW | Thread next PCs |
| chg_o | output | 1 | A status changed last edge |
| active_o | output | 1 | Stage active flag |
| wake_o | output | 1 | Stage turned active |
| sleep_o | output | 1 | Stage turned inactive |
| flush_o | output | NT | Redirect taken, remove younger work |
| bp_squash_o | output | NT | Predictor repair request |
| bp_fix_o | output | NT | Repair carries a mispredict |
| bp_update_o | output | NT | Predictor retire request |

## Verification
The checks assume that an unblock pulse arrives only for a stall bit that is already set, and never in the same cycle as a block pulse on that bit. The stimulus respects this: every unblock in the vector table and in the directed tests follows an earlier block on the same bit. The checks also assume that `miss_i` and `resp_i` are only meaningful in the matching status. The bench therefore exercises their no-effect cases by observing `status_o` alone.

// File: rtl/fetch_thread_status.sv
module fetch_thread_status #(
  parameter int NT = 2,
  parameter int NS = 4,
  parameter int AW = 32,
  parameter int INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT*NS-1:0] blk_i,
  input  logic [NT*NS-1:0] unb_i,
  input  logic             ctx_switch_i,
  input  logic [NT-1:0]    late_sq_i,
  input  logic [NT-1:0]    late_mp_i,
  input  logic [NT*AW-1:0] late_tgt_i,
  input  logic [NT-1:0]    done_i,
  input  logic [NT-1:0]    sq_busy_i,
  input  logic [NT-1:0]    early_sq_i,
  input  logic [NT-1:0]    early_mp_i,
  input  logic [NT*AW-1:0] early_tgt_i,
  input  logic [NT-1:0]    miss_i,
  input  logic [NT-1:0]    resp_i,
  input  logic [NT-1:0]    sel_i,
  input  logic [NT-1:0]    thr_act_i,
  output logic [NT*3-1:0]  status_o,
  output logic [NT*NS-1:0] stall_o,
  output logic [NT*AW-1:0] pc_o,
  output logic [NT*AW-1:0] npc_o,
  output logic             chg_o,
  output logic             active_o,
  output logic             wake_o,
  output logic             sleep_o,
  output logic [NT-1:0]    flush_o,
  output logic [NT-1:0]    bp_squash_o,
  output logic [NT-1:0]    bp_fix_o,
  output logic [NT-1:0]    bp_update_o
);

  typedef enum logic [2:0] {
    ST_RUN = 3'd0, ST_IDLE = 3'd1, ST_SQ = 3'd2, ST_BLK = 3'd3,
    ST_WRESP = 3'd4, ST_WRETRY = 3'd5, ST_DONE = 3'd6, ST_TRAP = 3'd7
  } fstat_e;

  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [NT*NS-1:0] stall_q, stall_d;
  logic [NT-1:0]    live_d, diff_d;
  logic             any_live, chg_d;

  assign stall_d  = (stall_q | blk_i) & ~(unb_i & ~blk_i);
  assign any_live = |(live_d & thr_act_i);
  assign chg_d    = |diff_d;
  assign stall_o  = stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q  <= '0;
      chg_o    <= 1'b0;
      active_o <= 1'b1;
      wake_o   <= 1'b0;
      sleep_o  <= 1'b0;
    end else begin
      stall_q <= stall_d;
      chg_o   <= chg_d;
      wake_o  <= chg_d & any_live & ~active_o;
      sleep_o <= chg_d & ~any_live & active_o;
      if (chg_d) active_o <= any_live;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fstat_e        st_q, st_d;
    logic [AW-1:0] pc_q, npc_q, tgt;
    logic          stalled, e_act, e_redir, redir;

    assign stalled = (|stall_d[t*NS +: NS]) | ctx_switch_i;
    assign e_act   = early_sq_i[t] & ~late_sq_i[t] & ~sq_busy_i[t];
    assign e_redir = e_act & (st_q != ST_SQ);
    assign redir   = late_sq_i[t] | e_redir;
    assign tgt     = late_sq_i[t] ? late_tgt_i[t*AW +: AW] : early_tgt_i[t*AW +: AW];

    always_comb begin
      st_d = st_q;
      if (late_sq_i[t] || sq_busy_i[t] || e_redir)
        st_d = ST_SQ;
      else if (stalled && st_q != ST_WRESP)
        st_d = ST_BLK;
      else if (st_q == ST_BLK || st_q == ST_SQ)
        st_d = ST_RUN;
      else if (st_q == ST_WRESP && resp_i[t])
        st_d = stalled ? ST_BLK : ST_DONE;
      else if (st_q == ST_DONE && sel_i[t])
        st_d = ST_RUN;
      else if (st_q == ST_RUN && miss_i[t])
        st_d = ST_WRESP;
    end

    assign live_d[t] = (st_d == ST_RUN) || (st_d == ST_SQ) || (st_d == ST_DONE);
    assign diff_d[t] = (st_d != st_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q           <= ST_RUN;
        pc_q           <= RESET_PC;
        npc_q          <= RESET_PC + STEP;
        flush_o[t]     <= 1'b0;
        bp_squash_o[t] <= 1'b0;
        bp_fix_o[t]    <= 1'b0;
        bp_update_o[t] <= 1'b0;
      end else begin
        st_q           <= st_d;
        flush_o[t]     <= redir;
        bp_squash_o[t] <= late_sq_i[t] | e_act;
        bp_fix_o[t]    <= late_sq_i[t] ? late_mp_i[t] : (e_act & early_mp_i[t]);
        bp_update_o[t] <= done_i[t] & ~late_sq_i[t];
        if (redir) begin
          pc_q  <= tgt;
          npc_q <= tgt + STEP;
        end
      end
    end

    assign status_o[t*3 +: 3] = st_q;
    assign pc_o[t*AW +: AW]   = pc_q;
    assign npc_o[t*AW +: AW]  = npc_q;

    // R3
    late_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      late_sq_i[t] |=> (st_q == ST_SQ) && (pc_q == $past(late_tgt_i[t*AW +: AW]))
                       && (npc_q == pc_q + STEP));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_busy_i[t] && !late_sq_i[t]) |=> (st_q == ST_SQ) && $stable(pc_q));

    // R5
    early_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (early_sq_i[t] && st_q == ST_SQ && !late_sq_i[t]) |=> $stable(pc_q));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WRESP && !resp_i[t] && !late_sq_i[t] && !sq_busy_i[t] && !early_sq_i[t])
      |=> st_q == ST_WRESP);
  end

  for (genvar b = 0; b < NT*NS; b++) begin : g_bit
    // R2
    unblock_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unb_i[b] |-> stall_q[b] && !blk_i[b]);

    // R2
    block_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_i[b] |=> stall_q[b]);
  end

  // R10
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != $past(status_o)) |-> chg_o);

  // R10
  active_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_o |-> $stable(active_o));

endmodule

// File: tb/fetch_thread_status_tb.sv
module fetch_thread_status_tb;
  localparam int NT = 2, NS = 4, AW = 32;
  localparam logic [AW-1:0] LT = 32'h0000_1000, ET = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT*NS-1:0] blk_i = '0, unb_i = '0;
  logic ctx_switch_i = 1'b0;
  logic [NT-1:0] late_sq_i = '0, late_mp_i = '0, done_i = '0, sq_busy_i = '0;
  logic [NT-1:0] early_sq_i = '0, early_mp_i = '0, miss_i = '0, resp_i = '0, sel_i = '0;
  logic [NT-1:0] thr_act_i = '1;
  logic [NT*AW-1:0] late_tgt_i = {LT, LT}, early_tgt_i = {ET, ET};
  logic [NT*3-1:0] status_o;
  logic [NT*NS-1:0] stall_o;
  logic [NT*AW-1:0] pc_o, npc_o;
  logic chg_o, active_o, wake_o, sleep_o;
  logic [NT-1:0] flush_o, bp_squash_o, bp_fix_o, bp_update_o;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  fetch_thread_status u_dut (.*);

  // ctrl: late sqbusy early blk_dec unb_dec ctx miss resp sel | expected thread0 status
  localparam logic [11:0] VEC [20] = '{
    {9'b000000100, 3'd4}, {9'b000100000, 3'd4}, {9'b000000010, 3'd3}, {9'b000010000, 3'd0},
    {9'b000000100, 3'd4}, {9'b000000010, 3'd6}, {9'b000000000, 3'd6}, {9'b000000001, 3'd0},
    {9'b000001000, 3'd3}, {9'b000000000, 3'd0}, {9'b001000000, 3'd2}, {9'b001000000, 3'd0},
    {9'b010000000, 3'd2}, {9'b010000000, 3'd2}, {9'b000000000, 3'd0}, {9'b100100000, 3'd2},
    {9'b000000000, 3'd3}, {9'b000010000, 3'd0}, {9'b000000010, 3'd0}, {9'b000000001, 3'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    blk_i = '0; unb_i = '0; ctx_switch_i = 0; late_sq_i = '0; late_mp_i = '0;
    done_i = '0; sq_busy_i = '0; early_sq_i = '0; early_mp_i = '0;
    miss_i = '0; resp_i = '0; sel_i = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 status", status_o, 0);
    check("R1 stall", stall_o, 0);
    check("R1 pc", pc_o[AW-1:0], 0);
    check("R1 npc", npc_o[AW-1:0], 4);
    check("R1 active/chg", {active_o, chg_o, wake_o, sleep_o}, 4'b1000);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      clear_in();
      {late_sq_i[0], sq_busy_i[0], early_sq_i[0], blk_i[0], unb_i[0],
       ctx_switch_i, miss_i[0], resp_i[0], sel_i[0]} = VEC[i][11:3];
      @(posedge clk); #1;
      check($sformatf("R3-R9 table step %0d status", i), status_o[2:0], VEC[i][2:0]);
      if (i == 10) check("R5 early redirect pc", pc_o[AW-1:0], ET);
      if (i == 11) check("R5 early ignored while squashing", pc_o[AW-1:0], ET);
      if (i == 12) check("R4 busy keeps pc", pc_o[AW-1:0], ET);
      if (i == 15) begin
        check("R3 late pc", pc_o[AW-1:0], LT);
        check("R3 late npc", npc_o[AW-1:0], LT + 4);
        check("R3 flush", flush_o[0], 1);
        check("R2 block beside late squash", stall_o[0], 1);
      end
      if (i == 17) check("R2 unblock clears", stall_o[0], 0);
    end

    @(negedge clk); clear_in();
    blk_i[1*NS+2] = 1'b1;
    step();
    check("R2 thread1 execute bit", stall_o, 8'b0100_0000);
    check("R6 thread1 blocked", status_o[5:3], 3);
    check("R6 thread0 untouched", status_o[2:0], 0);
    unb_i[1*NS+2] = 1'b1;
    step();
    check("R7 thread1 recovers", status_o[5:3], 0);
    check("R2 bit cleared", stall_o, 0);

    miss_i[0] = 1; step();
    blk_i[3] = 1; step();
    check("R6 wait response not blocked", status_o[2:0], 4);
    unb_i[3] = 1; step();
    resp_i[0] = 1; step();
    check("R8 completion", status_o[2:0], 6);
    resp_i[0] = 1; step();
    check("R8 resp ignored outside wait", status_o[2:0], 6);
    sel_i[0] = 1; step();
    check("R9 selected", status_o[2:0], 0);

    thr_act_i = 2'b01;
    blk_i[1] = 1; step();
    check("R10 chg pulse", chg_o, 1);
    check("R10 inactive", {active_o, sleep_o, wake_o}, 3'b010);
    step();
    check("R10 no chg", {chg_o, sleep_o}, 2'b00);
    thr_act_i = 2'b11; step();
    check("R10 active only on change", active_o, 0);
    unb_i[1] = 1; step();
    check("R10 wake", {active_o, wake_o, chg_o}, 3'b111);

    late_sq_i[1] = 1; late_mp_i[1] = 1; done_i[1] = 1; early_sq_i[1] = 1; step();
    check("R11 late repair", {bp_squash_o[1], bp_fix_o[1], bp_update_o[1]}, 3'b110);
    step();
    done_i[0] = 1; early_sq_i[0] = 1; early_mp_i[0] = 1; step();
    check("R11 early repair and update", {bp_squash_o[0], bp_fix_o[0], bp_update_o[0], flush_o[0]}, 4'b1111);
    sq_busy_i[0] = 1; early_sq_i[0] = 1; step();
    check("R11 early masked by busy", {bp_squash_o[0], flush_o[0]}, 2'b00);

    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R1 reset again", {status_o, stall_o}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule